// File: doc/BRIEF.md
# Binary Partition Mismatch Tree

This block scores one motion-search candidate against a 16x16 binary macroblock. Both the current block and the candidate arrive as one bit per pixel. Each pixel pair is compared with an XOR, where a 1 marks a mismatch. The block then reports how many pixels disagree inside every one of the 41 variable-size partitions of the macroblock. All 41 counts for one candidate come out together, so a downstream minimum selector can pick the best vector for every partition shape in a single pass.

The counting is hierarchical. Small lookup counters each cover four horizontally adjacent pixels of one row. Their results are added into 4x4 block counts. Pairs of 4x4 counts form the 8x4 and 4x8 counts. Pairs of 4x8 counts form the 8x8 counts. The 8x8 counts then form the two half-block shapes, and the two 8x16 halves give the whole-block total. A new candidate may be presented on every clock. A valid flag travels alongside the data, so the output flag marks the cycles in which all counts belong to one candidate.

Top module: `vbs_mismatch_tree`

## Requirements
- R1: Pixel (row r, column c) is bit r*16+c of `cur_blk` and of `cand_blk`. A pixel counts as a mismatch when its two bits differ. Identical blocks give a count of 0 everywhere, and fully complementary blocks give the full partition area everywhere.
- R2: `mm_4x4` holds sixteen 5-bit fields. Field i = br*4+bc sits at bits [5i+4:5i] and counts the mismatches in rows 4br..4br+3 and columns 4bc..4bc+3.
- R3: `mm_8x4` (8 wide, 4 tall) holds eight 6-bit fields. Field i = r*2+c sits at bits [6i+5:6i] and covers rows 4r..4r+3 and columns 8c..8c+7.
- R4: `mm_4x8` (4 wide, 8 tall) holds eight 6-bit fields. Field i = r*4+c sits at bits [6i+5:6i] and covers rows 8r..8r+7 and columns 4c..4c+3.
- R5: `mm_8x8` holds four 7-bit fields. Field i = r*2+c sits at bits [7i+6:7i] and covers rows 8r..8r+7 and columns 8c..8c+7.
- R6: `mm_16x8` (16 wide, 8 tall) holds two 8-bit fields, with field 0 covering the top half and field 1 the bottom half. `mm_8x16` (8 wide, 16 tall) holds two 8-bit fields, with field 0 covering the left half and field 1 the right half.
- R7: `mm_16x16` is a 9-bit count of all 256 pixels and can reach 256.
- R8: A candidate sampled with `in_valid` high at rising edge k produces `out_valid` high and its 41 counts after rising edge k+2. A new candidate is accepted on every edge, and `out_valid` is `in_valid` delayed by those three edges.
- R9: While `rst_n` is low, and until three edges have passed with `rst_n` high, `out_valid` is 0. During reset all count outputs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Candidate on the inputs is to be scored |
| cur_blk | input | 256 | Binary current macroblock, bit r*16+c |
| cand_blk | input | 256 | Binary candidate block, bit r*16+c |
| out_valid | output | 1 | All counts belong to one valid candidate |
| mm_4x4 | output | 80 | Sixteen 5-bit 4x4 counts |
| mm_8x4 | output | 48 | Eight 6-bit counts, 8 wide by 4 tall |
| mm_4x8 | output | 48 | Eight 6-bit counts, 4 wide by 8 tall |
| mm_8x8 | output | 28 | Four 7-bit 8x8 counts |
| mm_16x8 | output | 16 | Two 8-bit counts, top and bottom halves |
| mm_8x16 | output | 16 | Two 8-bit counts, left and right halves |
| mm_16x16 | output | 9 | Whole-block count |

## Verification
The first pattern is a sweep that sets a single mismatching pixel at each of the 256 positions in turn. This exposes any wrong bit-to-partition mapping, because exactly one field of each shape must read 1. Identical blocks and complementary blocks pin the all-zero and full-area extremes, including the 9-bit top count of 256. Row and column stripes and checkerboards separate the horizontal shapes from the vertical ones. Back-to-back pseudo-random candidates with gaps in `in_valid`, and a reset in mid-stream, test that the three-edge alignment keeps every count with its own candidate.

// File: rtl/vbs_mt_pkg.sv
package vbs_mt_pkg;
    localparam int MB_DIM      = 16;
    localparam int SEG         = 4;
    localparam int NPIX        = MB_DIM * MB_DIM;
    localparam int SEG_PER_ROW = MB_DIM / SEG;
    localparam int N_SEG       = MB_DIM * SEG_PER_ROW;
    localparam int BLK         = SEG;
    localparam int NB_SIDE     = MB_DIM / BLK;
    localparam int N4          = NB_SIDE * NB_SIDE;
    localparam int NHALF       = N4 / 2;
    localparam int N8          = N4 / 4;
    localparam int N16H        = 2;
    localparam int SEG_W       = $clog2(SEG + 1);
    localparam int W4          = $clog2(BLK * BLK + 1);
    localparam int W48         = $clog2(2 * BLK * BLK + 1);
    localparam int W8          = $clog2(4 * BLK * BLK + 1);
    localparam int W816        = $clog2(8 * BLK * BLK + 1);
    localparam int W16         = $clog2(NPIX + 1);

    typedef logic [SEG_W-1:0] seg_cnt_t;
    typedef logic [W4-1:0]    cnt4_t;
    typedef logic [W48-1:0]   cnt48_t;
    typedef logic [W8-1:0]    cnt8_t;
    typedef logic [W816-1:0]  cnt816_t;
    typedef logic [W16-1:0]   cnt16_t;

    // 16-entry population-count table for a 4-bit mismatch nibble
    function automatic seg_cnt_t pop4_lut(input logic [3:0] v);
        seg_cnt_t r;
        unique case (v)
            4'h0: r = 3'd0;
            4'h1: r = 3'd1;
            4'h2: r = 3'd1;
            4'h3: r = 3'd2;
            4'h4: r = 3'd1;
            4'h5: r = 3'd2;
            4'h6: r = 3'd2;
            4'h7: r = 3'd3;
            4'h8: r = 3'd1;
            4'h9: r = 3'd2;
            4'hA: r = 3'd2;
            4'hB: r = 3'd3;
            4'hC: r = 3'd2;
            4'hD: r = 3'd3;
            4'hE: r = 3'd3;
            default: r = 3'd4;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/mt_xor_count.sv
module mt_xor_count
    import vbs_mt_pkg::*;
(
    input  logic [SEG-1:0] cur_seg,
    input  logic [SEG-1:0] cand_seg,
    output seg_cnt_t       miss_cnt
);
    always_comb begin
        miss_cnt = pop4_lut(cur_seg ^ cand_seg);
    end
endmodule

// File: rtl/mt_count_stage.sv
module mt_count_stage
    import vbs_mt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [NPIX-1:0]         cur_blk,
    input  logic [NPIX-1:0]         cand_blk,
    output seg_cnt_t [N_SEG-1:0]    seg_q,
    output logic                    valid_q
);
    seg_cnt_t [N_SEG-1:0] seg_d;

    for (genvar k = 0; k < N_SEG; k++) begin : g_seg
        localparam int ROW  = k / SEG_PER_ROW;
        localparam int COL0 = (k % SEG_PER_ROW) * SEG;
        mt_xor_count u_cnt (
            .cur_seg  (cur_blk[ROW*MB_DIM+COL0 +: SEG]),
            .cand_seg (cand_blk[ROW*MB_DIM+COL0 +: SEG]),
            .miss_cnt (seg_d[k])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            seg_q   <= seg_d;
            valid_q <= in_valid;
        end
    end
endmodule

// File: rtl/mt_mid_stage.sv
module mt_mid_stage
    import vbs_mt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  seg_cnt_t [N_SEG-1:0]   seg_q,
    input  logic                   valid_in,
    output cnt4_t    [N4-1:0]      b4_q,
    output cnt48_t   [NHALF-1:0]   wide_q,
    output cnt48_t   [NHALF-1:0]   tall_q,
    output logic                   valid_q
);
    cnt4_t  [N4-1:0]    b4_d;
    cnt48_t [NHALF-1:0] wide_d;
    cnt48_t [NHALF-1:0] tall_d;

    always_comb begin
        for (int br = 0; br < NB_SIDE; br++) begin
            for (int bc = 0; bc < NB_SIDE; bc++) begin
                b4_d[br*NB_SIDE+bc] = '0;
                for (int r = 0; r < BLK; r++) begin
                    b4_d[br*NB_SIDE+bc] = b4_d[br*NB_SIDE+bc]
                        + W4'(seg_q[(br*BLK+r)*SEG_PER_ROW+bc]);
                end
            end
        end
        // 8 wide, 4 tall: horizontal pairs of 4x4
        for (int r = 0; r < NB_SIDE; r++) begin
            for (int c = 0; c < NB_SIDE/2; c++) begin
                wide_d[r*(NB_SIDE/2)+c] = W48'(b4_d[r*NB_SIDE+2*c])
                                        + W48'(b4_d[r*NB_SIDE+2*c+1]);
            end
        end
        // 4 wide, 8 tall: vertical pairs of 4x4
        for (int r = 0; r < NB_SIDE/2; r++) begin
            for (int c = 0; c < NB_SIDE; c++) begin
                tall_d[r*NB_SIDE+c] = W48'(b4_d[(2*r)*NB_SIDE+c])
                                    + W48'(b4_d[(2*r+1)*NB_SIDE+c]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b4_q    <= '0;
            wide_q  <= '0;
            tall_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            b4_q    <= b4_d;
            wide_q  <= wide_d;
            tall_q  <= tall_d;
            valid_q <= valid_in;
        end
    end
endmodule

// File: rtl/mt_top_stage.sv
module mt_top_stage
    import vbs_mt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  cnt4_t    [N4-1:0]      b4_in,
    input  cnt48_t   [NHALF-1:0]   wide_in,
    input  cnt48_t   [NHALF-1:0]   tall_in,
    input  logic                   valid_in,
    output cnt4_t    [N4-1:0]      b4_q,
    output cnt48_t   [NHALF-1:0]   wide_q,
    output cnt48_t   [NHALF-1:0]   tall_q,
    output cnt8_t    [N8-1:0]      q8_q,
    output cnt816_t  [N16H-1:0]    horiz_q,
    output cnt816_t  [N16H-1:0]    vert_q,
    output cnt16_t                 total,
    output logic                   valid_q
);
    cnt8_t   [N8-1:0]   q8_d;
    cnt816_t [N16H-1:0] horiz_d;
    cnt816_t [N16H-1:0] vert_d;

    always_comb begin
        // 8x8 from pairs of 4-wide 8-tall counts
        for (int r = 0; r < 2; r++) begin
            for (int c = 0; c < 2; c++) begin
                q8_d[r*2+c] = W8'(tall_in[r*NB_SIDE+2*c])
                            + W8'(tall_in[r*NB_SIDE+2*c+1]);
            end
        end
        for (int h = 0; h < N16H; h++) begin
            horiz_d[h] = W816'(q8_d[2*h]) + W816'(q8_d[2*h+1]);
            vert_d[h]  = W816'(q8_d[h])   + W816'(q8_d[h+2]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b4_q    <= '0;
            wide_q  <= '0;
            tall_q  <= '0;
            q8_q    <= '0;
            horiz_q <= '0;
            vert_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            b4_q    <= b4_in;
            wide_q  <= wide_in;
            tall_q  <= tall_in;
            q8_q    <= q8_d;
            horiz_q <= horiz_d;
            vert_q  <= vert_d;
            valid_q <= valid_in;
        end
    end

    assign total = W16'(vert_q[0]) + W16'(vert_q[1]);
endmodule

// File: rtl/vbs_mismatch_tree.sv
module vbs_mismatch_tree
    import vbs_mt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [NPIX-1:0]          cur_blk,
    input  logic [NPIX-1:0]          cand_blk,
    output logic                     out_valid,
    output logic [N4*W4-1:0]         mm_4x4,
    output logic [NHALF*W48-1:0]     mm_8x4,
    output logic [NHALF*W48-1:0]     mm_4x8,
    output logic [N8*W8-1:0]         mm_8x8,
    output logic [N16H*W816-1:0]     mm_16x8,
    output logic [N16H*W816-1:0]     mm_8x16,
    output logic [W16-1:0]           mm_16x16
);
    seg_cnt_t [N_SEG-1:0] seg_q;
    logic                 v1;
    cnt4_t    [N4-1:0]    b4_m;
    cnt48_t   [NHALF-1:0] wide_m;
    cnt48_t   [NHALF-1:0] tall_m;
    logic                 v2;
    cnt4_t    [N4-1:0]    b4_o;
    cnt48_t   [NHALF-1:0] wide_o;
    cnt48_t   [NHALF-1:0] tall_o;
    cnt8_t    [N8-1:0]    q8_o;
    cnt816_t  [N16H-1:0]  horiz_o;
    cnt816_t  [N16H-1:0]  vert_o;
    cnt16_t               total_o;
    logic                 v3;

    mt_count_stage u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .cur_blk  (cur_blk),
        .cand_blk (cand_blk),
        .seg_q    (seg_q),
        .valid_q  (v1)
    );

    mt_mid_stage u_mid (
        .clk      (clk),
        .rst_n    (rst_n),
        .seg_q    (seg_q),
        .valid_in (v1),
        .b4_q     (b4_m),
        .wide_q   (wide_m),
        .tall_q   (tall_m),
        .valid_q  (v2)
    );

    mt_top_stage u_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .b4_in    (b4_m),
        .wide_in  (wide_m),
        .tall_in  (tall_m),
        .valid_in (v2),
        .b4_q     (b4_o),
        .wide_q   (wide_o),
        .tall_q   (tall_o),
        .q8_q     (q8_o),
        .horiz_q  (horiz_o),
        .vert_q   (vert_o),
        .total    (total_o),
        .valid_q  (v3)
    );

    assign out_valid = v3;
    assign mm_4x4    = b4_o;
    assign mm_8x4    = wide_o;
    assign mm_4x8    = tall_o;
    assign mm_8x8    = q8_o;
    assign mm_16x8   = horiz_o;
    assign mm_8x16   = vert_o;
    assign mm_16x16  = total_o;
endmodule

// File: rtl/vbs_mismatch_tree_chk.sv
module vbs_mismatch_tree_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [255:0] cur_blk,
    input logic [255:0] cand_blk,
    input logic         out_valid,
    input logic [79:0]  mm_4x4,
    input logic [47:0]  mm_8x4,
    input logic [47:0]  mm_4x8,
    input logic [27:0]  mm_8x8,
    input logic [15:0]  mm_16x8,
    input logic [15:0]  mm_8x16,
    input logic [8:0]   mm_16x16
);
    logic [1:0] age;
    logic       same_now;

    assign same_now = (cur_blk == cand_blk);

    always_ff @(posedge clk) begin
        if (!rst_n)         age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R9: no valid output before the pipeline has refilled
    assert_fill_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd3) |-> !out_valid);

    // R8: output flag is the input flag three edges later
    assert_valid_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R1: identical blocks score zero
    assert_same_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && out_valid && $past(same_now, 3)) |-> (mm_16x16 == 9'd0));

    // R7: whole block equals both half splits
    assert_total_split_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mm_16x16 == 9'(mm_8x16[7:0]) + 9'(mm_8x16[15:8])) &&
                      (mm_16x16 == 9'(mm_16x8[7:0]) + 9'(mm_16x8[15:8])));

    // R6: top half is the two upper 8x8 counts
    assert_half_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mm_16x8[7:0] == 8'(mm_8x8[6:0]) + 8'(mm_8x8[13:7])));

    for (genvar q = 0; q < 4; q++) begin : g_quad
        localparam int QR = q / 2;
        localparam int QC = q % 2;
        localparam int B0 = (2*QR)*4 + 2*QC;
        // R5: 8x8 equals its four 4x4 counts
        assert_quad_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (mm_8x8[q*7 +: 7] ==
                7'(mm_4x4[B0*5 +: 5]) + 7'(mm_4x4[(B0+1)*5 +: 5]) +
                7'(mm_4x4[(B0+4)*5 +: 5]) + 7'(mm_4x4[(B0+5)*5 +: 5])));
    end

    for (genvar i = 0; i < 8; i++) begin : g_half
        localparam int WR = i / 2;
        localparam int WC = i % 2;
        localparam int TR = i / 4;
        localparam int TC = i % 4;
        // R3: wide field is a horizontal pair of 4x4
        assert_wide_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (mm_8x4[i*6 +: 6] ==
                6'(mm_4x4[(WR*4+2*WC)*5 +: 5]) + 6'(mm_4x4[(WR*4+2*WC+1)*5 +: 5])));
        // R4: tall field is a vertical pair of 4x4
        assert_tall_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (mm_4x8[i*6 +: 6] ==
                6'(mm_4x4[(2*TR*4+TC)*5 +: 5]) + 6'(mm_4x4[((2*TR+1)*4+TC)*5 +: 5])));
    end

    for (genvar b = 0; b < 16; b++) begin : g_blk
        // R2: a 4x4 count never exceeds its area
        assert_blk_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (mm_4x4[b*5 +: 5] <= 5'd16));
    end
endmodule

bind vbs_mismatch_tree vbs_mismatch_tree_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .cur_blk  (cur_blk),
    .cand_blk (cand_blk),
    .out_valid(out_valid),
    .mm_4x4   (mm_4x4),
    .mm_8x4   (mm_8x4),
    .mm_4x8   (mm_4x8),
    .mm_8x8   (mm_8x8),
    .mm_16x8  (mm_16x8),
    .mm_8x16  (mm_8x16),
    .mm_16x16 (mm_16x16)
);

// File: tb/vbs_mismatch_tree_test.sv
module vbs_mismatch_tree_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] cur_blk = '0;
    logic [255:0] cand_blk = '0;
    logic         out_valid;
    logic [79:0]  mm_4x4;
    logic [47:0]  mm_8x4;
    logic [47:0]  mm_4x8;
    logic [27:0]  mm_8x8;
    logic [15:0]  mm_16x8;
    logic [15:0]  mm_8x16;
    logic [8:0]   mm_16x16;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [255:0] hd [3];
    logic         hv [3];
    logic [31:0]  lfsr = 32'hACE1_1234;

    always #10 clk = ~clk;

    vbs_mismatch_tree uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cur_blk(cur_blk), .cand_blk(cand_blk), .out_valid(out_valid),
        .mm_4x4(mm_4x4), .mm_8x4(mm_8x4), .mm_4x8(mm_4x8), .mm_8x8(mm_8x8),
        .mm_16x8(mm_16x8), .mm_8x16(mm_8x16), .mm_16x16(mm_16x16)
    );

    function automatic int region(logic [255:0] d, int r0, int c0, int h, int w);
        int n = 0;
        for (int r = r0; r < r0 + h; r++)
            for (int c = c0; c < c0 + w; c++)
                n += int'(d[r*16+c]);
        return n;
    endfunction

    task automatic chk(bit ok, string req, logic [79:0] act, logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    function automatic logic [255:0] rand_blk();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = next_rand();
        return v;
    endfunction

    task automatic compare_out();
        logic [79:0] e4;
        logic [47:0] e84, e48;
        logic [27:0] e8;
        logic [15:0] e168, e816;
        logic [8:0]  e16;
        logic [255:0] d;
        chk(out_valid == hv[2], "R8 out_valid", 80'(out_valid), 80'(hv[2]));
        if (hv[2]) begin
            d = hd[2];
            for (int i = 0; i < 16; i++) e4[i*5 +: 5] = 5'(region(d, (i/4)*4, (i%4)*4, 4, 4));
            for (int i = 0; i < 8; i++)  e84[i*6 +: 6] = 6'(region(d, (i/2)*4, (i%2)*8, 4, 8));
            for (int i = 0; i < 8; i++)  e48[i*6 +: 6] = 6'(region(d, (i/4)*8, (i%4)*4, 8, 4));
            for (int i = 0; i < 4; i++)  e8[i*7 +: 7] = 7'(region(d, (i/2)*8, (i%2)*8, 8, 8));
            for (int i = 0; i < 2; i++)  e168[i*8 +: 8] = 8'(region(d, i*8, 0, 8, 16));
            for (int i = 0; i < 2; i++)  e816[i*8 +: 8] = 8'(region(d, 0, i*8, 16, 8));
            e16 = 9'(region(d, 0, 0, 16, 16));
            chk(mm_4x4 == e4,     "R2 4x4",   80'(mm_4x4),   80'(e4));
            chk(mm_8x4 == e84,    "R3 8x4",   80'(mm_8x4),   80'(e84));
            chk(mm_4x8 == e48,    "R4 4x8",   80'(mm_4x8),   80'(e48));
            chk(mm_8x8 == e8,     "R5 8x8",   80'(mm_8x8),   80'(e8));
            chk(mm_16x8 == e168,  "R6 16x8",  80'(mm_16x8),  80'(e168));
            chk(mm_8x16 == e816,  "R6 8x16",  80'(mm_8x16),  80'(e816));
            chk(mm_16x16 == e16,  "R7 16x16", 80'(mm_16x16), 80'(e16));
        end
    endtask

    task automatic step(logic v, logic [255:0] cb, logic [255:0] sb);
        in_valid = v;
        cur_blk  = cb;
        cand_blk = sb;
        @(posedge clk);
        hd[2] = hd[1]; hv[2] = hv[1];
        hd[1] = hd[0]; hv[1] = hv[0];
        hd[0] = cb ^ sb; hv[0] = v && rst_n;
        if (!rst_n) begin
            hv[0] = 1'b0; hv[1] = 1'b0; hv[2] = 1'b0;
        end
        @(negedge clk);
        compare_out();
    endtask

    initial begin
        logic [255:0] a, pat;
        for (int i = 0; i < 3; i++) begin hd[i] = '0; hv[i] = 1'b0; end
        @(negedge clk);
        step(1'b1, rand_blk(), rand_blk());
        step(1'b1, rand_blk(), rand_blk());
        chk(out_valid == 1'b0, "R9 reset valid", 80'(out_valid), 80'd0);
        chk(mm_16x16 == 9'd0 && mm_4x4 == '0, "R9 reset counts", 80'(mm_16x16), 80'd0);
        rst_n = 1'b1;

        // R1: identical then complementary blocks
        a = rand_blk();
        step(1'b1, a, a);
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
        chk(mm_16x16 == 9'd0, "R1 identical", 80'(mm_16x16), 80'd0);
        step(1'b1, a, ~a);
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
        chk(mm_16x16 == 9'd256, "R1 complement", 80'(mm_16x16), 80'd256);

        // single-pixel sweep, back to back
        for (int p = 0; p < 256; p++) begin
            a = rand_blk();
            step(1'b1, a, a ^ (256'd1 << p));
        end

        // stripes and checkerboards
        for (int k = 0; k < 4; k++) begin
            pat = '0;
            for (int r = 0; r < 16; r++)
                for (int c = 0; c < 16; c++)
                    case (k)
                        0: pat[r*16+c] = r[0];
                        1: pat[r*16+c] = c[0];
                        2: pat[r*16+c] = r[0] ^ c[0];
                        default: pat[r*16+c] = r[2] ^ c[3];
                    endcase
            step(1'b1, '0, pat);
        end

        // random stream with gaps in the valid flag
        for (int n = 0; n < 400; n++)
            step((n % 3) != 2, rand_blk(), rand_blk());

        // R9: reset in mid-stream
        step(1'b1, rand_blk(), rand_blk());
        rst_n = 1'b0;
        step(1'b1, rand_blk(), rand_blk());
        chk(out_valid == 1'b0, "R9 mid reset", 80'(out_valid), 80'd0);
        rst_n = 1'b1;
        for (int n = 0; n < 6; n++) step(1'b1, rand_blk(), rand_blk());
        for (int n = 0; n < 4; n++) step(1'b0, '0, '0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule